// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache-line misses that are still in flight for an in-order pipeline whose loads do not block. Each of a few entries holds one line address and one optional register tag per word of that line. A load that misses either opens a new entry, which issues one memory request, or joins an entry that is already waiting for the same line. The load then leaves the pipeline, and its destination register is marked empty in a full/empty scoreboard.

Decode asks the scoreboard about two source registers and is held only while one of them is empty. A miss by itself never holds decode. When the memory returns a line, the block stores the whole line at once. It then writes the waiting registers back, one per cycle, and marks each of them full. The entry is released together with its last writeback. If a newer miss names a register that an older waiting slot already targets, the older slot is dropped. A stale value therefore cannot land on top of the newer result.

Top module: `mshr_file`

## Requirements
- R1: After reset, no entry is busy and every register reads full. `decode_hold`, `mem_req_valid` and `wb_valid` are all low.
- R2: A miss whose line matches no pending entry is accepted into the lowest-numbered free entry. In the same cycle it raises `mem_req_valid`, with `mem_req_line` equal to the line and `mem_req_id` equal to that entry's index. From the next cycle on, its destination register reads empty.
- R3: A miss whose line matches an entry that is still waiting for its refill is merged into that entry when its word slot is free. No memory request is raised, and the register reads empty from the next cycle.
- R4: `alloc_stall` is high when the matching pending entry already holds a register for the requested word, or when there is no match and all entries are busy. A stalled miss changes nothing: no request is raised and its register stays full.
- R5: `decode_hold` is high in exactly those cycles in which `query_ra` or `query_rb` names an empty register.
- R6: `refill_id` selects the entry and `refill_data` carries word w at bits [w*DATA_W +: DATA_W]. Writebacks of the filled entry start the cycle after the refill. There is one per cycle, in ascending word order, and each carries the data of its word.
- R7: A register that has been written back reads full from the next cycle, unless a new miss to it is accepted in that same cycle.
- R8: An entry is released in the cycle of its last writeback, or in the cycle after its refill if it has no slots left. A later new miss can reuse it.
- R9: Accepting a miss for register r drops every older waiting slot that targets r, so r is written back only with the newer load's word.
- R10: Memory requests are raised only for new allocations. An entry that is busy never receives a second request.
- R11: When several refilled entries are waiting to drain, each writeback cycle serves the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A load miss is presented |
| alloc_line | input | LINE_W | Line address of the miss |
| alloc_word | input | log2(WORDS) | Word offset within the line |
| alloc_rd | input | log2(NUM_REGS) | Destination register of the load |
| alloc_stall | output | 1 | The presented miss cannot be taken this cycle |
| mem_req_valid | output | 1 | Issue a line fetch |
| mem_req_line | output | LINE_W | Line to fetch |
| mem_req_id | output | log2(ENTRIES) | Entry that will receive the line |
| query_ra | input | log2(NUM_REGS) | First source register from decode |
| query_rb | input | log2(NUM_REGS) | Second source register from decode |
| decode_hold | output | 1 | A queried register is still empty |
| refill_valid | input | 1 | A line returns from memory |
| refill_id | input | log2(ENTRIES) | Entry the line belongs to |
| refill_data | input | WORDS*DATA_W | The whole line, word 0 in the low bits |
| wb_valid | output | 1 | A register write is presented |
| wb_rd | output | log2(NUM_REGS) | Register being written |
| wb_data | output | DATA_W | Value written |

## Verification
The assertions rely on the memory side to return a line only for an entry that is busy and has not yet been filled, and at most once for each request. The stimulus honours this by refilling only entry indices it has seen in `mem_req_id` and never refilling the same index again before it is reused. The other assertions are invariants among the entry table, the lookup and the scoreboard. Examples are that a writeback always targets a register still marked empty, and that a free entry holds no slots. These invariants hold for any sequence of miss, query and refill inputs that obeys this one rule.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
   localparam int unsigned MSHR_MAX_ENTRIES = 32;
   localparam int unsigned MSHR_MAX_WORDS   = 32;

   // index of the lowest set bit, 0 when none is set
   function automatic int lowest_set(input logic [31:0] vec);
      int idx;
      idx = 0;
      for (int i = 31; i >= 0; i--) begin
         if (vec[i]) idx = i;
      end
      return idx;
   endfunction
endpackage

// File: rtl/mshr_lookup.sv
module mshr_lookup
   import mshr_pkg::*;
#(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned WORDS   = 4,
   parameter int unsigned LINE_W  = 26,
   localparam int unsigned EID_W  = $clog2(ENTRIES),
   localparam int unsigned WOFF_W = $clog2(WORDS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ENTRIES-1:0]               busy,
   input  logic [ENTRIES-1:0]               filled,
   input  logic [ENTRIES-1:0][LINE_W-1:0]   lines,
   input  logic [ENTRIES-1:0][WORDS-1:0]    slot_v,
   input  logic [LINE_W-1:0]                req_line,
   input  logic [WOFF_W-1:0]                req_word,
   output logic                             hit,
   output logic [EID_W-1:0]                 hit_idx,
   output logic                             any_free,
   output logic [EID_W-1:0]                 free_idx,
   output logic                             stall
);
   logic [ENTRIES-1:0] match;

   genvar e;
   generate
      for (e = 0; e < ENTRIES; e++) begin : g_cmp
         assign match[e] = busy[e] & ~filled[e] & (lines[e] == req_line);
      end
   endgenerate

   always_comb begin
      hit      = |match;
      any_free = ~&busy;
      hit_idx  = EID_W'(lowest_set(32'(match)));
      free_idx = EID_W'(lowest_set(32'(~busy)));
      stall    = hit ? slot_v[hit_idx][req_word] : ~any_free;
   end

   // R3: a line is never pending in two entries at once
   p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/mshr_drain.sv
module mshr_drain
   import mshr_pkg::*;
#(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned WORDS   = 4,
   localparam int unsigned EID_W  = $clog2(ENTRIES),
   localparam int unsigned WOFF_W = $clog2(WORDS)
) (
   input  logic [ENTRIES-1:0]            busy,
   input  logic [ENTRIES-1:0]            filled,
   input  logic [ENTRIES-1:0][WORDS-1:0] slot_v,
   output logic                          sel_valid,
   output logic [EID_W-1:0]              sel_idx,
   output logic                          word_valid,
   output logic [WOFF_W-1:0]             word_idx,
   output logic                          last
);
   logic [ENTRIES-1:0] cand;
   logic [WORDS-1:0]   words;
   logic [WORDS-1:0]   remaining;

   always_comb begin
      cand       = busy & filled;
      sel_valid  = |cand;
      sel_idx    = EID_W'(lowest_set(32'(cand)));
      words      = slot_v[sel_idx];
      word_valid = sel_valid & (|words);
      word_idx   = WOFF_W'(lowest_set(32'(words)));
      remaining  = words & ~(WORDS'(1) << word_idx);
      last       = word_valid & (remaining == '0);
   end
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fill_en,
   input  logic [REG_W-1:0]    fill_rd,
   input  logic                pend_en,
   input  logic [REG_W-1:0]    pend_rd,
   input  logic [REG_W-1:0]    rd_a,
   input  logic [REG_W-1:0]    rd_b,
   output logic                hold,
   output logic [NUM_REGS-1:0] empty_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= '0;
      end else begin
         if (fill_en) empty_q[fill_rd] <= 1'b0;
         // a newly accepted miss wins over a writeback of the same register
         if (pend_en) empty_q[pend_rd] <= 1'b1;
      end
   end

   assign hold = empty_q[rd_a] | empty_q[rd_b];
endmodule

// File: rtl/mshr_file.sv
module mshr_file
   import mshr_pkg::*;
#(
   parameter int unsigned ENTRIES  = 4,
   parameter int unsigned WORDS    = 4,
   parameter int unsigned LINE_W   = 26,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned EID_W   = $clog2(ENTRIES),
   localparam int unsigned WOFF_W  = $clog2(WORDS),
   localparam int unsigned REG_W   = $clog2(NUM_REGS),
   localparam int unsigned LINE_DW = WORDS * DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_valid,
   input  logic [LINE_W-1:0]   alloc_line,
   input  logic [WOFF_W-1:0]   alloc_word,
   input  logic [REG_W-1:0]    alloc_rd,
   output logic                alloc_stall,
   output logic                mem_req_valid,
   output logic [LINE_W-1:0]   mem_req_line,
   output logic [EID_W-1:0]    mem_req_id,
   input  logic [REG_W-1:0]    query_ra,
   input  logic [REG_W-1:0]    query_rb,
   output logic                decode_hold,
   input  logic                refill_valid,
   input  logic [EID_W-1:0]    refill_id,
   input  logic [LINE_DW-1:0]  refill_data,
   output logic                wb_valid,
   output logic [REG_W-1:0]    wb_rd,
   output logic [DATA_W-1:0]   wb_data
);
   initial begin
      assert (ENTRIES >= 2 && ENTRIES <= MSHR_MAX_ENTRIES && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("ENTRIES must be a power of two in 2..32");
      assert (WORDS >= 2 && WORDS <= MSHR_MAX_WORDS && (WORDS & (WORDS - 1)) == 0)
         else $error("WORDS must be a power of two in 2..32");
      assert (NUM_REGS >= 2 && (NUM_REGS & (NUM_REGS - 1)) == 0)
         else $error("NUM_REGS must be a power of two");
   end

   // entry table
   logic [ENTRIES-1:0]              busy;
   logic [ENTRIES-1:0]              filled;
   logic [ENTRIES-1:0][LINE_W-1:0]  ent_line;
   logic [ENTRIES-1:0][WORDS-1:0]   slot_v;
   logic [REG_W-1:0]                slot_rd  [ENTRIES][WORDS];
   logic [DATA_W-1:0]               slot_dat [ENTRIES][WORDS];

   logic               hit, any_free, stall;
   logic [EID_W-1:0]   hit_idx, free_idx, tgt;
   logic               accept;
   logic               sel_valid, word_valid, last;
   logic [EID_W-1:0]   sel_idx;
   logic [WOFF_W-1:0]  word_idx;
   logic [NUM_REGS-1:0] reg_empty;

   mshr_lookup #(.ENTRIES(ENTRIES), .WORDS(WORDS), .LINE_W(LINE_W)) u_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .filled   (filled),
      .lines    (ent_line),
      .slot_v   (slot_v),
      .req_line (alloc_line),
      .req_word (alloc_word),
      .hit      (hit),
      .hit_idx  (hit_idx),
      .any_free (any_free),
      .free_idx (free_idx),
      .stall    (stall)
   );

   mshr_drain #(.ENTRIES(ENTRIES), .WORDS(WORDS)) u_drain (
      .busy       (busy),
      .filled     (filled),
      .slot_v     (slot_v),
      .sel_valid  (sel_valid),
      .sel_idx    (sel_idx),
      .word_valid (word_valid),
      .word_idx   (word_idx),
      .last       (last)
   );

   assign accept = alloc_valid & ~stall;
   assign tgt    = hit ? hit_idx : free_idx;

   // control state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= '0;
         filled <= '0;
         slot_v <= '0;
      end else begin
         if (sel_valid) begin
            if (word_valid) slot_v[sel_idx][word_idx] <= 1'b0;
            if (!word_valid || last) begin
               busy[sel_idx]   <= 1'b0;
               filled[sel_idx] <= 1'b0;
            end
         end
         if (accept) begin
            for (int e = 0; e < ENTRIES; e++) begin
               for (int w = 0; w < WORDS; w++) begin
                  if (slot_v[e][w] && slot_rd[e][w] == alloc_rd) slot_v[e][w] <= 1'b0;
               end
            end
            slot_v[tgt][alloc_word] <= 1'b1;
            if (!hit) begin
               busy[tgt]   <= 1'b1;
               filled[tgt] <= 1'b0;
            end
         end
         if (refill_valid) filled[refill_id] <= 1'b1;
      end
   end

   // payload state, no reset needed
   always_ff @(posedge clk) begin
      if (accept) begin
         slot_rd[tgt][alloc_word] <= alloc_rd;
         if (!hit) ent_line[tgt] <= alloc_line;
      end
      if (refill_valid) begin
         for (int w = 0; w < WORDS; w++) begin
            slot_dat[refill_id][w] <= refill_data[w*DATA_W +: DATA_W];
         end
      end
   end

   mshr_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
      .clk     (clk),
      .rst_n   (rst_n),
      .fill_en (wb_valid),
      .fill_rd (wb_rd),
      .pend_en (accept),
      .pend_rd (alloc_rd),
      .rd_a    (query_ra),
      .rd_b    (query_rb),
      .hold    (decode_hold),
      .empty_q (reg_empty)
   );

   assign alloc_stall   = stall;
   assign mem_req_valid = accept & ~hit;
   assign mem_req_line  = alloc_line;
   assign mem_req_id    = free_idx;
   assign wb_valid      = word_valid;
   assign wb_rd         = slot_rd[sel_idx][word_idx];
   assign wb_data       = slot_dat[sel_idx][word_idx];

   // R10: a request never targets an entry that is already outstanding
   p_one_req_per_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !busy[mem_req_id]);

   // R2: the requested entry is busy on the following cycle
   p_entry_busy_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> busy[$past(mem_req_id)]);

   // R7: every writeback lands on a register the scoreboard holds empty
   p_wb_target_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> reg_empty[wb_rd]);

   // R6: refills only arrive for busy entries still waiting
   p_refill_to_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refill_valid |-> (busy[refill_id] && !filled[refill_id]));

   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_chk
         // R8: a released entry carries no waiting slots
         p_idle_entry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[g] |-> (slot_v[g] == '0));
      end
   endgenerate
endmodule

// File: tb/tb_mshr_file.sv
`timescale 1ns/1ps
module tb_mshr_file;
   localparam int NE = 4, NW = 4, LW = 26, DW = 32, NR = 32;
   localparam real PERIOD = 5.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 1'b0;
   logic [LW-1:0] alloc_line = '0;
   logic [1:0] alloc_word = '0;
   logic [4:0] alloc_rd = '0;
   logic alloc_stall, mem_req_valid, decode_hold, wb_valid;
   logic [LW-1:0] mem_req_line;
   logic [1:0] mem_req_id;
   logic [4:0] query_ra = '0, query_rb = '0, wb_rd;
   logic refill_valid = 1'b0;
   logic [1:0] refill_id = '0;
   logic [NW*DW-1:0] refill_data = '0;
   logic [DW-1:0] wb_data;

   always #(PERIOD/2) clk = ~clk;

   mshr_file dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_line(alloc_line), .alloc_word(alloc_word),
      .alloc_rd(alloc_rd), .alloc_stall(alloc_stall),
      .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_id(mem_req_id),
      .query_ra(query_ra), .query_rb(query_rb), .decode_hold(decode_hold),
      .refill_valid(refill_valid), .refill_id(refill_id), .refill_data(refill_data),
      .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // behavioural reference state
   bit m_busy[NE], m_fill[NE];
   logic [LW-1:0] m_line[NE];
   bit m_sv[NE][NW];
   int m_rd[NE][NW];
   logic [DW-1:0] m_dat[NE][NW];
   bit [NR-1:0] m_empty;

   // last observed outputs and logs
   bit o_stall, o_req, o_hold;
   int o_id;
   int wb_log[$];
   logic [DW-1:0] wbd_log[$];
   int req_count = 0;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] dval(input int e, input int w);
      return 32'hA500_0000 + 32'(e * 16 + w);
   endfunction

   task automatic step();
      int hit, fr, sel, wd, tgt;
      bit stall, acc, ereq, ehold, ewb, any;
      #1;
      hit = -1; fr = -1; sel = -1; wd = -1;
      for (int e = NE - 1; e >= 0; e--) begin
         if (m_busy[e] && !m_fill[e] && m_line[e] == alloc_line) hit = e;
         if (!m_busy[e]) fr = e;
         if (m_busy[e] && m_fill[e]) sel = e;
      end
      stall = (hit >= 0) ? m_sv[hit][alloc_word] : (fr < 0);
      acc   = alloc_valid && !stall;
      ereq  = acc && hit < 0;
      ehold = m_empty[query_ra] || m_empty[query_rb];
      if (sel >= 0)
         for (int w = NW - 1; w >= 0; w--) if (m_sv[sel][w]) wd = w;
      ewb = (sel >= 0) && (wd >= 0);

      chk(alloc_stall == stall, "R4", "alloc_stall", alloc_stall, stall);
      chk(mem_req_valid == ereq, "R10", "mem_req_valid", mem_req_valid, ereq);
      if (ereq) begin
         chk(mem_req_id == 2'(fr), "R2", "mem_req_id", mem_req_id, fr);
         chk(mem_req_line == alloc_line, "R2", "mem_req_line", mem_req_line, alloc_line);
      end
      chk(decode_hold == ehold, "R5", "decode_hold", decode_hold, ehold);
      chk(wb_valid == ewb, "R6", "wb_valid", wb_valid, ewb);
      if (ewb) begin
         chk(wb_rd == 5'(m_rd[sel][wd]), "R6", "wb_rd", wb_rd, m_rd[sel][wd]);
         chk(wb_data == m_dat[sel][wd], "R6", "wb_data", wb_data, m_dat[sel][wd]);
      end
      o_stall = alloc_stall; o_req = mem_req_valid; o_hold = decode_hold; o_id = int'(mem_req_id);
      if (mem_req_valid) req_count++;
      if (wb_valid) begin wb_log.push_back(int'(wb_rd)); wbd_log.push_back(wb_data); end

      @(posedge clk);
      if (sel >= 0) begin
         if (ewb) begin
            m_sv[sel][wd] = 0;
            m_empty[m_rd[sel][wd]] = 0;
         end
         any = 0;
         for (int w = 0; w < NW; w++) any |= m_sv[sel][w];
         if (!any) begin m_busy[sel] = 0; m_fill[sel] = 0; end
      end
      if (acc) begin
         for (int e = 0; e < NE; e++)
            for (int w = 0; w < NW; w++)
               if (m_sv[e][w] && m_rd[e][w] == int'(alloc_rd)) m_sv[e][w] = 0;
         tgt = (hit >= 0) ? hit : fr;
         m_sv[tgt][alloc_word] = 1;
         m_rd[tgt][alloc_word] = int'(alloc_rd);
         if (hit < 0) begin m_busy[tgt] = 1; m_fill[tgt] = 0; m_line[tgt] = alloc_line; end
         m_empty[alloc_rd] = 1;
      end
      if (refill_valid) begin
         m_fill[refill_id] = 1;
         for (int w = 0; w < NW; w++) m_dat[refill_id][w] = refill_data[w*DW +: DW];
      end
      @(negedge clk);
      alloc_valid = 0;
      refill_valid = 0;
   endtask

   task automatic do_alloc(input int line, input int word, input int rd);
      alloc_valid = 1; alloc_line = LW'(line); alloc_word = 2'(word); alloc_rd = 5'(rd);
      step();
   endtask

   task automatic do_query(input int ra, input int rb);
      query_ra = 5'(ra); query_rb = 5'(rb);
      step();
   endtask

   task automatic do_refill(input int id);
      refill_valid = 1; refill_id = 2'(id);
      for (int w = 0; w < NW; w++) refill_data[w*DW +: DW] = dval(id, w);
      step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      m_empty = '0;
      for (int e = 0; e < NE; e++) begin
         m_busy[e] = 0; m_fill[e] = 0; m_line[e] = '0;
         for (int w = 0; w < NW; w++) begin m_sv[e][w] = 0; m_rd[e][w] = 0; m_dat[e][w] = '0; end
      end
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      do_query(5, 7);
      chk(!o_hold && !o_req && wb_log.size() == 0, "R1", "idle after reset", {o_hold, o_req}, 0);

      // R2: new line A word1 -> entry 0
      do_alloc(100, 1, 5);
      chk(o_req && o_id == 0, "R2", "first allocation id", o_id, 0);
      do_query(5, 0);
      chk(o_hold, "R5", "hold on empty r5", o_hold, 1);

      // R3: merge into A
      do_alloc(100, 3, 7);
      chk(!o_req && !o_stall, "R3", "merge no request", {o_req, o_stall}, 0);

      // R4: slot conflict stalls and leaves r9 full
      do_alloc(100, 1, 9);
      chk(o_stall, "R4", "slot taken stall", o_stall, 1);
      do_query(9, 9);
      chk(!o_hold, "R4", "stalled rd stays full", o_hold, 0);

      // fill the table, R9 cancel of r5 inside A
      do_alloc(200, 0, 5);
      chk(o_req && o_id == 1, "R2", "second allocation id", o_id, 1);
      do_alloc(300, 0, 11);
      do_alloc(300, 1, 12);
      chk(!o_req, "R3", "merge into C", o_req, 0);
      do_alloc(200, 2, 10);
      do_alloc(400, 2, 13);
      chk(o_req && o_id == 3, "R2", "fourth allocation id", o_id, 3);
      do_alloc(500, 0, 20);
      chk(o_stall && !o_req, "R4", "table full stall", o_stall, 1);
      do_query(20, 20);
      chk(!o_hold, "R4", "full stall leaves r20 full", o_hold, 0);

      // refill A: only r7 (word 3) returns, r5 was cancelled
      wb_log.delete(); wbd_log.delete();
      do_refill(0);
      idle(3);
      chk(wb_log.size() == 1, "R9", "writebacks from A", wb_log.size(), 1);
      if (wb_log.size() == 1) begin
         chk(wb_log[0] == 7, "R9", "writeback reg", wb_log[0], 7);
         chk(wbd_log[0] == dval(0, 3), "R6", "word3 data", wbd_log[0], dval(0, 3));
      end

      // R8: entry 0 reusable
      do_alloc(500, 0, 20);
      chk(o_req && o_id == 0, "R8", "freed entry reused", o_id, 0);

      // R11: refill C then B; lower entry preempts
      wb_log.delete(); wbd_log.delete();
      do_refill(2);
      do_refill(1);
      idle(5);
      chk(wb_log.size() == 4, "R11", "drain count", wb_log.size(), 4);
      if (wb_log.size() == 4) begin
         chk(wb_log[0] == 11, "R11", "drain slot 0", wb_log[0], 11);
         chk(wb_log[1] == 5,  "R11", "drain slot 1", wb_log[1], 5);
         chk(wb_log[2] == 10, "R6",  "drain slot 2", wb_log[2], 10);
         chk(wb_log[3] == 12, "R11", "drain slot 3", wb_log[3], 12);
         chk(wbd_log[2] == dval(1, 2), "R6", "entry1 word2 data", wbd_log[2], dval(1, 2));
      end

      // R7: written registers are full, pending one is not
      do_query(5, 10);
      chk(!o_hold, "R7", "r5 r10 full", o_hold, 0);
      do_query(11, 12);
      chk(!o_hold, "R7", "r11 r12 full", o_hold, 0);
      do_query(13, 0);
      chk(o_hold, "R5", "r13 still pending", o_hold, 1);

      // R10: exactly five line requests so far
      chk(req_count == 5, "R10", "request count", req_count, 5);

      do_refill(3);
      do_refill(0);
      idle(4);
      do_query(13, 20);
      chk(!o_hold, "R7", "all registers full", o_hold, 0);
      finish_run();
   end
endmodule